// File: doc/BRIEF.md
# Key-Guarded Watchdog Register Front End

This block is the software-facing register layer for a two-stage watchdog timer. It sits on a simple memory-mapped bus carrying address, write data, access size (byte, half-word or word), a write strobe and a read strobe. It holds the values the countdown core needs: two stage preloads, the mode bits (reboot permission, tick rate, first-stage interrupt kind), and the enable, free-run and sticky lock bits. It also turns software commands into single-cycle pulses for the core: a keep-alive pulse and a pulse that clears the record of a watchdog-caused reboot. The countdown itself lives elsewhere.

Writes that matter are guarded. Software must first write the byte value 0x80 and then 0x86 to the reload offset (0xC). Only then is one following half-word or word write acted upon, and that write uses up the unlock. Mode and lock settings come in through a separate configuration port. Once the lock bit has been set, the enable, free-run and lock bits are frozen until reset. The reboot-record flag is set by the core through an input pin and can be read back on the bus.

Top module: `wdt_keyed_regs`

## Requirements
- R1: After reset, both preloads read 0xFFFFF, reboot is permitted, the slow tick rate and interrupt kind 0 are selected, enable, free-run and lock are 0, the reboot-record flag is 0, read data is 0 and no pulse is active.
- R2: A write of exactly 0x80 to offset 0xC (any size) arms the first key step. A write of exactly 0x86 to offset 0xC while the first step is armed opens the guard. The next non-byte write that is not 0x80 to offset 0xC is acted upon and closes the guard again, so a second guarded write needs a fresh key pair.
- R3: While open, a word write to offset 0x0 loads the first-stage preload, and one to offset 0x4 loads the second-stage preload. Each takes the low 20 bits of the data and is visible the cycle after the write.
- R4: While open, a half-word write to offset 0xC with data bit 8 set gives a keep-alive pulse of exactly one cycle, starting the cycle after the write.
- R5: While open, a half-word write to offset 0xC with data bit 9 or bit 12 set gives a one-cycle clear pulse and clears the reboot-record flag. Asserting the flag-set input sets the flag on that edge. If both happen in the same cycle, the set wins.
- R6: Byte writes can only advance or restart the key sequence. A byte write never loads a preload, never pulses, and never closes an open guard.
- R7: Without a completed key pair, writes to offsets 0x0, 0x4 and 0xC have no effect and leave the key state unchanged. A key pair that follows still works.
- R8: A read returns its data the cycle after the read strobe. A half-word read of 0xC returns 0x1200 when the reboot-record flag is set and 0 otherwise. Every other read returns 0.
- R9: A configuration write with select 0 sets reboot permission to the inverse of data bit 5, the fast tick rate to data bit 2, and the interrupt kind to data bits 1:0. This register stays writable after lock.
- R10: A configuration write with select 1 loads lock from data bit 0, enable from bit 1 and free-run from bit 2, unless lock is already set. In that case the write is ignored until reset.
- R11: A non-byte guarded write that matches no action (for example a half-word write to 0x0, or a word write to 0xC) still closes the guard without changing any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 4 | Byte offset |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects mode register, 1 selects lock register |
| cfg_wdata | input | 8 | Configuration write data |
| rb_flag_set | input | 1 | Core reports a watchdog-caused reboot |
| preload1 | output | 20 | First-stage preload |
| preload2 | output | 20 | Second-stage preload |
| keepalive_p | output | 1 | One-cycle keep-alive pulse |
| flag_clr_p | output | 1 | One-cycle reboot-record clear pulse |
| prev_reboot | output | 1 | Reboot-record flag |
| reboot_en | output | 1 | Reboot permitted on final expiry |
| fast_tick | output | 1 | Fast tick rate selected |
| irq_kind | output | 2 | First-stage interrupt kind |
| wd_enable | output | 1 | Watchdog enabled |
| free_run | output | 1 | Restart stage one after final expiry |
| wd_locked | output | 1 | Lock bit |

## Verification
The reboot-record flag has two owners. The core sets it through rb_flag_set, and software clears it through a guarded half-word write, so the two can land on the same edge. The bench opens the guard and then sends a half-word write with bits 8 and 9 set while rb_flag_set is high. It then checks that both pulses fire, that the flag remains set, and that a later half-word read of 0xC returns 0x1200. Random runs also assert the set input at arbitrary points among guarded writes, and a reference model in the bench judges each outcome.

// File: rtl/wdt_kr_pkg.sv
package wdt_kr_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      UL_IDLE = 2'd0,
      UL_HALF = 2'd1,
      UL_OPEN = 2'd2
   } unlock_e;

   typedef struct packed {
      logic       reboot_en;
      logic       fast_tick;
      logic [1:0] irq_kind;
   } mode_t;

   typedef struct packed {
      logic locked;
      logic enable;
      logic free_run;
   } lockreg_t;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_kr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY_A = 'h80,
   parameter logic [DATA_W-1:0] KEY_B = 'h86
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              at_reload,
   input  logic              is_byte,
   input  logic [DATA_W-1:0] wdata,
   output logic              accept
);

   unlock_e st_q, st_d;
   logic    hit_a, hit_b;

   assign hit_a  = wr_en && at_reload && (wdata == KEY_A);
   assign hit_b  = wr_en && at_reload && (wdata == KEY_B) && (st_q == UL_HALF);
   assign accept = wr_en && (st_q == UL_OPEN) && !hit_a && !is_byte;

   always_comb begin
      st_d = st_q;
      if (hit_a)
         st_d = UL_HALF;
      else if (hit_b)
         st_d = UL_OPEN;
      else if (accept)
         st_d = UL_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= UL_IDLE;
      else
         st_q <= st_d;
   end

endmodule

// File: rtl/wdt_prot_dec.sv
module wdt_prot_dec
   import wdt_kr_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned PRELOAD_W    = 20,
   parameter int unsigned NSTAGE       = 2,
   parameter int unsigned STAGE_STRIDE = 4,
   parameter int unsigned RELOAD_OFF   = 12,
   parameter int unsigned KA_BIT       = 8,
   parameter int unsigned CLR_BIT_A    = 9,
   parameter int unsigned CLR_BIT_B    = 12
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               accept,
   input  logic [ADDR_W-1:0]                  addr,
   input  acc_size_e                          size,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [NSTAGE-1:0][PRELOAD_W-1:0]   preload,
   output logic                               keepalive_p,
   output logic                               flag_clr_p,
   output logic                               clr_req
);

   localparam logic [ADDR_W-1:0] RELOAD_A = ADDR_W'(RELOAD_OFF);

   logic             half_hit;
   logic             ka_req;
   logic [PRELOAD_W-1:0] pl_q [NSTAGE];

   assign half_hit = accept && (size == SZ_HALF) && (addr == RELOAD_A);
   assign ka_req   = half_hit && wdata[KA_BIT];
   assign clr_req  = half_hit && (wdata[CLR_BIT_A] || wdata[CLR_BIT_B]);

   for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
      localparam logic [ADDR_W-1:0] STG_OFF = ADDR_W'(g * STAGE_STRIDE);
      always_ff @(posedge clk) begin
         if (!rst_n)
            pl_q[g] <= '1;
         else if (accept && (size == SZ_WORD) && (addr == STG_OFF))
            pl_q[g] <= wdata[PRELOAD_W-1:0];
      end
   end

   always_comb begin
      for (int i = 0; i < NSTAGE; i++)
         preload[i] = pl_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keepalive_p <= 1'b0;
         flag_clr_p  <= 1'b0;
      end else begin
         keepalive_p <= ka_req;
         flag_clr_p  <= clr_req;
      end
   end

endmodule

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
   import wdt_kr_pkg::*;
#(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned NOREB_BIT  = 5,
   parameter int unsigned FAST_BIT   = 2,
   parameter int unsigned KIND_LSB   = 0,
   parameter int unsigned LOCK_BIT   = 0,
   parameter int unsigned EN_BIT     = 1,
   parameter int unsigned FREE_BIT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             flag_set,
   input  logic             flag_clr,
   output mode_t            mode,
   output lockreg_t         lkr,
   output logic             flag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= '{reboot_en: 1'b1, fast_tick: 1'b0, irq_kind: 2'd0};
      end else if (cfg_wr && !cfg_sel) begin
         mode.reboot_en <= !cfg_wdata[NOREB_BIT];
         mode.fast_tick <= cfg_wdata[FAST_BIT];
         mode.irq_kind  <= cfg_wdata[KIND_LSB +: 2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lkr <= '0;
      end else if (cfg_wr && cfg_sel && !lkr.locked) begin
         lkr.locked   <= cfg_wdata[LOCK_BIT];
         lkr.enable   <= cfg_wdata[EN_BIT];
         lkr.free_run <= cfg_wdata[FREE_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (flag_set)
         flag <= 1'b1;
      else if (flag_clr)
         flag <= 1'b0;
   end

endmodule

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
   import wdt_kr_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned PRELOAD_W  = 20,
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned RELOAD_OFF = 12,
   parameter int unsigned FLAG_RDVAL = 'h1200,
   parameter bit          RD_REG     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 cfg_wr,
   input  logic                 cfg_sel,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic                 rb_flag_set,
   output logic [PRELOAD_W-1:0] preload1,
   output logic [PRELOAD_W-1:0] preload2,
   output logic                 keepalive_p,
   output logic                 flag_clr_p,
   output logic                 prev_reboot,
   output logic                 reboot_en,
   output logic                 fast_tick,
   output logic [1:0]           irq_kind,
   output logic                 wd_enable,
   output logic                 free_run,
   output logic                 wd_locked
);

   localparam int unsigned       NSTAGE   = 2;
   localparam logic [ADDR_W-1:0] RELOAD_A = ADDR_W'(RELOAD_OFF);

   if (DATA_W < 16) begin : g_bad_data_w
      $error("wdt_keyed_regs: DATA_W must be at least 16");
   end
   if (PRELOAD_W > DATA_W) begin : g_bad_preload_w
      $error("wdt_keyed_regs: PRELOAD_W cannot exceed DATA_W");
   end
   if (CFG_W < 6) begin : g_bad_cfg_w
      $error("wdt_keyed_regs: CFG_W must hold bit 5");
   end
   if (RELOAD_OFF >= (1 << ADDR_W)) begin : g_bad_off
      $error("wdt_keyed_regs: RELOAD_OFF outside address space");
   end

   acc_size_e                            size_e;
   logic                                 at_reload;
   logic                                 accept;
   logic                                 clr_req;
   logic [NSTAGE-1:0][PRELOAD_W-1:0]     pl;
   mode_t                                mode;
   lockreg_t                             lkr;
   logic [DATA_W-1:0]                    rd_val;

   assign size_e    = acc_size_e'(bus_size);
   assign at_reload = (bus_addr == RELOAD_A);

   wdt_key_seq #(
      .DATA_W (DATA_W)
   ) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .at_reload (at_reload),
      .is_byte   (size_e == SZ_BYTE),
      .wdata     (bus_wdata),
      .accept    (accept)
   );

   wdt_prot_dec #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .PRELOAD_W  (PRELOAD_W),
      .NSTAGE     (NSTAGE),
      .RELOAD_OFF (RELOAD_OFF)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .addr        (bus_addr),
      .size        (size_e),
      .wdata       (bus_wdata),
      .preload     (pl),
      .keepalive_p (keepalive_p),
      .flag_clr_p  (flag_clr_p),
      .clr_req     (clr_req)
   );

   wdt_ctl_regs #(
      .CFG_W (CFG_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .flag_set  (rb_flag_set),
      .flag_clr  (clr_req),
      .mode      (mode),
      .lkr       (lkr),
      .flag      (prev_reboot)
   );

   assign preload1  = pl[0];
   assign preload2  = pl[1];
   assign reboot_en = mode.reboot_en;
   assign fast_tick = mode.fast_tick;
   assign irq_kind  = mode.irq_kind;
   assign wd_enable = lkr.enable;
   assign free_run  = lkr.free_run;
   assign wd_locked = lkr.locked;

   assign rd_val = (bus_rd && (size_e == SZ_HALF) && at_reload && prev_reboot)
                   ? DATA_W'(FLAG_RDVAL) : '0;

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bus_rdata <= '0;
         else
            bus_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end

endmodule

// File: rtl/wdt_keyed_regs_chk.sv
module wdt_keyed_regs_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned PRELOAD_W = 20,
   parameter bit          RD_REG    = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [1:0]           bus_size,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 rb_flag_set,
   input logic [PRELOAD_W-1:0] preload1,
   input logic                 keepalive_p,
   input logic                 flag_clr_p,
   input logic                 prev_reboot,
   input logic                 wd_enable,
   input logic                 free_run,
   input logic                 wd_locked
);

   // R4
   keepalive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      keepalive_p |-> $past(bus_wr && (bus_addr == 4'hC) && (bus_size == 2'd1) && bus_wdata[8]));

   // R4
   keepalive_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      keepalive_p |=> !keepalive_p);

   // R5
   flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_flag_set |=> prev_reboot);

   // R5
   flag_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_p |-> $past(bus_wr && (bus_size == 2'd1) && (bus_wdata[9] || bus_wdata[12])));

   // R3
   preload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(preload1) |-> $past(bus_wr && (bus_size == 2'd2) && (bus_addr == 4'h0)));

   // R10
   lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wd_locked) |-> (wd_locked && $stable(wd_enable) && $stable(free_run)));

   if (RD_REG) begin : g_rd_chk
      // R8
      rdata_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rdata != '0) |-> $past(bus_rd && (bus_size == 2'd1) && prev_reboot));
   end

endmodule

bind wdt_keyed_regs wdt_keyed_regs_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .PRELOAD_W (PRELOAD_W),
   .RD_REG    (RD_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .bus_size    (bus_size),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .rb_flag_set (rb_flag_set),
   .preload1    (preload1),
   .keepalive_p (keepalive_p),
   .flag_clr_p  (flag_clr_p),
   .prev_reboot (prev_reboot),
   .wd_enable   (wd_enable),
   .free_run    (free_run),
   .wd_locked   (wd_locked)
);

// File: tb/wdt_keyed_regs_tb.sv
module wdt_keyed_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd, cfg_wr, cfg_sel, rb_flag_set;
   logic [3:0]  bus_addr;
   logic [1:0]  bus_size;
   logic [31:0] bus_wdata, bus_rdata;
   logic [7:0]  cfg_wdata;
   logic [19:0] preload1, preload2;
   logic        keepalive_p, flag_clr_p, prev_reboot;
   logic        reboot_en, fast_tick, wd_enable, free_run, wd_locked;
   logic [1:0]  irq_kind;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench reference state
   int          m_st;
   logic [19:0] m_pl1, m_pl2;
   logic        m_flag, m_ka, m_clr;
   logic        m_reb, m_fast, m_lk, m_en, m_fr;
   logic [1:0]  m_kind;

   always #10 clk = ~clk;

   wdt_keyed_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rb_flag_set(rb_flag_set),
      .preload1(preload1), .preload2(preload2), .keepalive_p(keepalive_p),
      .flag_clr_p(flag_clr_p), .prev_reboot(prev_reboot),
      .reboot_en(reboot_en), .fast_tick(fast_tick), .irq_kind(irq_kind),
      .wd_enable(wd_enable), .free_run(free_run), .wd_locked(wd_locked)
   );

   task automatic chkv(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
      return (a == 4'hC && sz == 2'd1 && m_flag) ? 32'h1200 : 32'h0;
   endfunction

   task automatic model_reset();
      m_st = 0; m_pl1 = 20'hFFFFF; m_pl2 = 20'hFFFFF; m_flag = 0;
      m_ka = 0; m_clr = 0; m_reb = 1; m_fast = 0; m_kind = 0;
      m_lk = 0; m_en = 0; m_fr = 0;
   endtask

   task automatic model_write(input logic [3:0] a, input logic [1:0] sz,
                              input logic [31:0] d, input logic setf);
      m_ka = 0; m_clr = 0;
      if (a == 4'hC && d == 32'h80) m_st = 1;
      else if (a == 4'hC && d == 32'h86 && m_st == 1) m_st = 2;
      else if (m_st == 2 && sz != 2'd0) begin
         if (sz == 2'd2 && a == 4'h0) m_pl1 = d[19:0];
         if (sz == 2'd2 && a == 4'h4) m_pl2 = d[19:0];
         if (sz == 2'd1 && a == 4'hC) begin
            m_ka  = d[8];
            m_clr = d[9] | d[12];
         end
         m_st = 0;
      end
      if (setf) m_flag = 1;
      else if (m_clr) m_flag = 0;
   endtask

   task automatic check_all();
      chkv("R4 keepalive", {31'd0, keepalive_p}, {31'd0, m_ka});
      chkv("R5 clear pulse", {31'd0, flag_clr_p}, {31'd0, m_clr});
      chkv("R5 flag", {31'd0, prev_reboot}, {31'd0, m_flag});
      chkv("R3 preload1", {12'd0, preload1}, {12'd0, m_pl1});
      chkv("R3 preload2", {12'd0, preload2}, {12'd0, m_pl2});
   endtask

   task automatic do_wr(input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic setf);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d; rb_flag_set = setf;
      model_write(a, sz, d, setf);
      @(posedge clk); #1;
      check_all();
      @(negedge clk);
      bus_wr = 0; rb_flag_set = 0;
   endtask

   task automatic do_rd(input logic [3:0] a, input logic [1:0] sz);
      logic [31:0] e;
      @(negedge clk);
      bus_rd = 1; bus_addr = a; bus_size = sz;
      e = exp_read(a, sz);
      @(posedge clk); #1;
      chkv("R8 read data", bus_rdata, e);
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic do_cfg(input logic sel, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
      if (!sel) begin
         m_reb = !d[5]; m_fast = d[2]; m_kind = d[1:0];
      end else if (!m_lk) begin
         m_lk = d[0]; m_en = d[1]; m_fr = d[2];
      end
      @(posedge clk); #1;
      chkv("R9 reboot_en", {31'd0, reboot_en}, {31'd0, m_reb});
      chkv("R9 fast_tick", {31'd0, fast_tick}, {31'd0, m_fast});
      chkv("R9 irq_kind", {30'd0, irq_kind}, {30'd0, m_kind});
      chkv("R10 locked", {31'd0, wd_locked}, {31'd0, m_lk});
      chkv("R10 enable", {31'd0, wd_enable}, {31'd0, m_en});
      chkv("R10 free_run", {31'd0, free_run}, {31'd0, m_fr});
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
      chkv("R1 preload1", {12'd0, preload1}, 32'hFFFFF);
      chkv("R1 preload2", {12'd0, preload2}, 32'hFFFFF);
      chkv("R1 mode", {28'd0, reboot_en, fast_tick, irq_kind}, 32'h8);
      chkv("R1 lock", {29'd0, wd_locked, wd_enable, free_run}, 32'h0);
      chkv("R1 pulses/flag", {29'd0, keepalive_p, flag_clr_p, prev_reboot}, 32'h0);
      chkv("R1 rdata", bus_rdata, 32'h0);
   endtask

   task automatic unlock();
      do_wr(4'hC, 2'd2, 32'h80, 0);
      do_wr(4'hC, 2'd2, 32'h86, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0]  a;
      logic [1:0]  sz;
      logic [31:0] d;
      void'($urandom(32'd20240607));
      rst_n = 0; bus_wr = 0; bus_rd = 0; cfg_wr = 0; cfg_sel = 0;
      bus_addr = 0; bus_size = 0; bus_wdata = 0; cfg_wdata = 0; rb_flag_set = 0;
      model_reset();
      apply_reset();

      // R7: no key, no effect
      do_wr(4'h0, 2'd2, 32'h12345, 0);
      chkv("R7 preload1 untouched", {12'd0, preload1}, 32'hFFFFF);
      do_wr(4'hC, 2'd1, 32'h100, 0);
      chkv("R7 no keepalive", {31'd0, keepalive_p}, 32'h0);

      // R2 + R3: one write per unlock
      unlock();
      do_wr(4'h0, 2'd2, 32'hABCDE123, 0);
      chkv("R3 low 20 bits", {12'd0, preload1}, 32'hDE123);
      do_wr(4'h4, 2'd2, 32'h55555, 0);
      chkv("R2 unlock consumed", {12'd0, preload2}, 32'hFFFFF);

      // R6: byte write does not consume; byte keys work
      unlock();
      do_wr(4'h0, 2'd0, 32'h11, 0);
      do_wr(4'h4, 2'd2, 32'h00777, 0);
      chkv("R6 byte kept guard open", {12'd0, preload2}, 32'h00777);
      do_wr(4'hC, 2'd0, 32'h80, 0);
      do_wr(4'hC, 2'd0, 32'h86, 0);
      do_wr(4'hC, 2'd1, 32'h100, 0);
      chkv("R6 byte keys then keepalive", {31'd0, keepalive_p}, 32'h1);

      // R11: non-matching guarded write closes guard
      unlock();
      do_wr(4'h0, 2'd1, 32'h999, 0);
      do_wr(4'h4, 2'd2, 32'h1, 0);
      chkv("R11 guard closed", {12'd0, preload2}, 32'h00777);

      // R5 / R8: flag set, read, clear, collision
      do_wr(4'h8, 2'd2, 32'h0, 1);
      chkv("R5 flag set", {31'd0, prev_reboot}, 32'h1);
      do_rd(4'hC, 2'd1);
      chkv("R8 flag read", bus_rdata, 32'h1200);
      do_rd(4'hC, 2'd2);
      do_rd(4'h0, 2'd1);
      unlock();
      do_wr(4'hC, 2'd1, 32'h1000, 0);
      chkv("R5 bit12 clears", {31'd0, prev_reboot}, 32'h0);
      do_wr(4'h8, 2'd2, 32'h0, 1);
      unlock();
      do_wr(4'hC, 2'd1, 32'h300, 1);
      chkv("R5 set wins collision", {30'd0, prev_reboot, flag_clr_p}, 32'h3);
      do_rd(4'hC, 2'd1);

      // R9 / R10
      do_cfg(0, 8'h24);
      do_cfg(0, 8'h03);
      do_cfg(1, 8'h06);
      do_cfg(1, 8'h03);
      do_cfg(1, 8'h00);
      chkv("R10 locked write ignored", {29'd0, wd_locked, wd_enable, free_run}, 32'h6);
      do_cfg(0, 8'h21);

      // random mix
      for (int i = 0; i < 800; i++) begin
         case ($urandom % 4)
            0: a = 4'h0;
            1: a = 4'h4;
            2: a = 4'h8;
            default: a = 4'hC;
         endcase
         sz = 2'($urandom % 3);
         case ($urandom % 8)
            0, 1: d = 32'h80;
            2, 3: d = 32'h86;
            default: d = $urandom;
         endcase
         if ($urandom % 10 == 0) do_rd(a, sz);
         else if ($urandom % 25 == 0) do_cfg(1'($urandom % 2), 8'($urandom));
         else do_wr(a, sz, d, ($urandom % 12) == 0);
      end

      // R1: reset releases lock
      apply_reset();
      do_cfg(1, 8'h02);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule